// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block sequences the copying of SRAM contents into a shadow nonvolatile array (STORE) and back again (RECALL) for a battery-free nonvolatile SRAM. It watches a synchronous supply-good flag, an active-low hardware store pin, a software command strobe, and the SRAM interface's access-activity and write strobes. It drives level controls to the array for the full length of each operation, a busy flag, and an inhibit that tells the SRAM interface to ignore accesses.

A loss of supply triggers an automatic STORE and a return of supply triggers a RECALL. The hardware pin is shared: the host pulls it low to ask for a STORE, and the block drives it low while a store is pending or running. No STORE is ever made unless an SRAM write has been accepted since the last completed nonvolatile operation. All durations are parameters counted in clock ticks.

Top module: `nvs_seq_ctrl`

## Requirements
- R1: From reset the block is off: no store, no recall, busy low, inhibit high, pin released. In the first cycle with supply_ok high while off, a power-up recall starts on the next clock edge. nv_recall then stays high for exactly PWRUP_RECALL_TICKS cycles.
- R2: inhibit is high whenever supply_ok is low or an operation is active. A wr_strobe is accepted, and sets the write-pending flag, only when inhibit is low.
- R3: A supply drop while idle with a write pending starts an automatic store on the next edge. nv_store stays high for STORE_TICKS cycles and hsb_oe is high with it. The block then goes off and stays there until supply returns.
- R4: A supply drop while idle with nothing pending goes straight to off with no store. The off state never holds a pending write.
- R5: With a write pending, hsb_in sampled low while idle starts a hardware store sequence. hsb_oe is high and hsb_o is low from the next cycle on, and busy is high.
- R6: After a hardware request the store waits in a grace window. It begins on the edge after acc_active is seen low, or after GRACE_TICKS grace cycles, whichever comes first.
- R7: A hardware or software store request that arrives with no write pending is ignored. busy stays low and no store happens.
- R8: sw_req with sw_recall=1 while idle runs a recall of SW_RECALL_TICKS cycles. sw_req with sw_recall=0 and a write pending runs a STORE_TICKS store that returns to idle.
- R9: Requests and writes that arrive while an operation is active are dropped and are not queued.
- R10: Among requests in the same idle cycle, supply loss wins over the hardware pin, and the hardware pin wins over software.
- R11: The pending flag clears at the end of every completed store or recall, so a second store request with no new write is ignored.
- R12: A supply drop during any recall abandons it on the next edge and goes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above the switch threshold (synchronous) |
| hsb_in | input | 1 | Sampled level of the shared store pin, low requests a store |
| hsb_oe | output | 1 | Output enable for the shared pin (busy flag) |
| hsb_o | output | 1 | Value driven on the pin, low while hsb_oe is high |
| sw_req | input | 1 | Software command strobe |
| sw_recall | input | 1 | Command kind with sw_req: 1 recall, 0 store |
| acc_active | input | 1 | An SRAM access is in progress |
| wr_strobe | input | 1 | SRAM write strobe, one per write |
| nv_store | output | 1 | Array store control, high for the whole store |
| nv_recall | output | 1 | Array recall control, high for the whole recall |
| busy | output | 1 | A nonvolatile operation or grace window is active |
| inhibit | output | 1 | SRAM accesses are to be ignored |

## Verification
The bench focuses on where requests collide or go stale. It tests supply loss, the pin and a software command arriving in the same cycle, and store requests made with no write pending. A design with the wrong priority would open a grace window, or run a manual store that returns to idle, when it should store and go off. A pending flag that never clears would cause a second store. The bench also issues writes and commands during a store, and drops the supply mid-recall. A design that queued these would start a late recall or an unwanted store, and one that ignored the drop would finish the recall with no power.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_PWR_RCL = 3'd1,
        ST_IDLE    = 3'd2,
        ST_GRACE   = 3'd3,
        ST_STORE   = 3'd4,
        ST_SW_RCL  = 3'd5
    } nvs_state_e;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_AUTO_STORE = 3'd1,
        OP_GO_OFF     = 3'd2,
        OP_GRACE      = 3'd3,
        OP_SW_STORE   = 3'd4,
        OP_SW_RECALL  = 3'd5
    } nvs_op_e;

    typedef struct packed {
        nvs_state_e st;
        logic       pend;
        logic       auto_st;
    } nvs_reg_t;

endpackage

// File: rtl/nvs_tick_timer.sv
module nvs_tick_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/nvs_idle_arb.sv
module nvs_idle_arb
    import nvs_pkg::*;
(
    input  logic    supply_ok,
    input  logic    hsb_low,
    input  logic    sw_req,
    input  logic    sw_recall,
    input  logic    pend,
    output nvs_op_e op
);
    always_comb begin
        op = OP_NONE;
        if (!supply_ok)
            op = pend ? OP_AUTO_STORE : OP_GO_OFF;
        else if (hsb_low && pend)
            op = OP_GRACE;
        else if (sw_req && !sw_recall && pend)
            op = OP_SW_STORE;
        else if (sw_req && sw_recall)
            op = OP_SW_RECALL;
    end
endmodule

// File: rtl/nvs_seq_ctrl.sv
module nvs_seq_ctrl
    import nvs_pkg::*;
#(
    parameter int unsigned STORE_TICKS        = 1250000,
    parameter int unsigned PWRUP_RECALL_TICKS = 2000000,
    parameter int unsigned SW_RECALL_TICKS    = 5000,
    parameter int unsigned GRACE_TICKS        = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic hsb_in,
    output logic hsb_oe,
    output logic hsb_o,
    input  logic sw_req,
    input  logic sw_recall,
    input  logic acc_active,
    input  logic wr_strobe,
    output logic nv_store,
    output logic nv_recall,
    output logic busy,
    output logic inhibit
);
    localparam int unsigned MAX_AB = (STORE_TICKS > PWRUP_RECALL_TICKS) ? STORE_TICKS : PWRUP_RECALL_TICKS;
    localparam int unsigned MAX_CD = (SW_RECALL_TICKS > GRACE_TICKS) ? SW_RECALL_TICKS : GRACE_TICKS;
    localparam int unsigned MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW = $clog2(MAX_T + 1);

    localparam logic [CW-1:0] LV_STORE = CW'(STORE_TICKS - 1);
    localparam logic [CW-1:0] LV_PWR   = CW'(PWRUP_RECALL_TICKS - 1);
    localparam logic [CW-1:0] LV_SW    = CW'(SW_RECALL_TICKS - 1);
    localparam logic [CW-1:0] LV_GRACE = CW'(GRACE_TICKS - 1);

    nvs_reg_t      cur_q, nxt_d;
    logic          load_d;
    logic [CW-1:0] lval_d;
    logic          expired;
    logic          wr_ok;
    nvs_op_e       idle_op;

    nvs_tick_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_d),
        .load_val (lval_d),
        .expired  (expired)
    );

    nvs_idle_arb u_arb (
        .supply_ok (supply_ok),
        .hsb_low   (!hsb_in),
        .sw_req    (sw_req),
        .sw_recall (sw_recall),
        .pend      (cur_q.pend),
        .op        (idle_op)
    );

    assign wr_ok = wr_strobe && (cur_q.st == ST_IDLE) && supply_ok;

    always_comb begin
        nxt_d  = cur_q;
        load_d = 1'b0;
        lval_d = '0;
        if (wr_ok) nxt_d.pend = 1'b1;
        case (cur_q.st)
            ST_OFF: begin
                if (supply_ok) begin
                    nxt_d.st = ST_PWR_RCL;
                    load_d   = 1'b1;
                    lval_d   = LV_PWR;
                end
            end
            ST_PWR_RCL, ST_SW_RCL: begin
                if (!supply_ok) begin
                    nxt_d.st   = ST_OFF;
                    nxt_d.pend = 1'b0;
                end else if (expired) begin
                    nxt_d.st   = ST_IDLE;
                    nxt_d.pend = 1'b0;
                end
            end
            ST_IDLE: begin
                case (idle_op)
                    OP_AUTO_STORE: begin
                        nxt_d.st      = ST_STORE;
                        nxt_d.auto_st = 1'b1;
                        load_d        = 1'b1;
                        lval_d        = LV_STORE;
                    end
                    OP_GO_OFF: begin
                        nxt_d.st   = ST_OFF;
                        nxt_d.pend = 1'b0;
                    end
                    OP_GRACE: begin
                        nxt_d.st = ST_GRACE;
                        load_d   = 1'b1;
                        lval_d   = LV_GRACE;
                    end
                    OP_SW_STORE: begin
                        nxt_d.st      = ST_STORE;
                        nxt_d.auto_st = 1'b0;
                        load_d        = 1'b1;
                        lval_d        = LV_STORE;
                    end
                    OP_SW_RECALL: begin
                        nxt_d.st = ST_SW_RCL;
                        load_d   = 1'b1;
                        lval_d   = LV_SW;
                    end
                    default: ;
                endcase
            end
            ST_GRACE: begin
                if (!supply_ok || !acc_active || expired) begin
                    nxt_d.st      = ST_STORE;
                    nxt_d.auto_st = !supply_ok;
                    load_d        = 1'b1;
                    lval_d        = LV_STORE;
                end
            end
            ST_STORE: begin
                if (expired) begin
                    nxt_d.pend    = 1'b0;
                    nxt_d.auto_st = 1'b0;
                    nxt_d.st      = (cur_q.auto_st || !supply_ok) ? ST_OFF : ST_IDLE;
                end
            end
            default: nxt_d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_OFF, pend: 1'b0, auto_st: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign nv_store  = (cur_q.st == ST_STORE);
    assign nv_recall = (cur_q.st == ST_PWR_RCL) || (cur_q.st == ST_SW_RCL);
    assign busy      = (cur_q.st != ST_IDLE) && (cur_q.st != ST_OFF);
    assign hsb_oe    = (cur_q.st == ST_GRACE) || (cur_q.st == ST_STORE);
    assign hsb_o     = !hsb_oe;
    assign inhibit   = (cur_q.st != ST_IDLE) || !supply_ok;

    // R7: a store only ever begins with a write pending
    a_r7_store_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_store) |-> $past(cur_q.pend));

    // R11: the pending flag is gone once a store has finished
    a_r11_clear_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nv_store) |-> !cur_q.pend);

    // R2: pending only rises from a write seen while idle with supply
    a_r2_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.pend) |-> $past(cur_q.st == ST_IDLE && supply_ok && wr_strobe));

    // R4: the off state holds no pending write
    a_r4_off_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_OFF) |-> !cur_q.pend);

    // R12: supply loss ends any recall on the next edge
    a_r12_recall_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_recall && !supply_ok) |=> !nv_recall);

endmodule

// File: tb/nvs_seq_ctrl_test.sv
module nvs_seq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int ST_T = 20;
    localparam int PR_T = 30;
    localparam int SR_T = 12;
    localparam int GR_T = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, hsb_in = 1'b1, sw_req = 1'b0, sw_recall = 1'b0;
    logic acc_active = 1'b0, wr_strobe = 1'b0;
    logic hsb_oe, hsb_o, nv_store, nv_recall, busy, inhibit;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvs_seq_ctrl #(
        .STORE_TICKS(ST_T), .PWRUP_RECALL_TICKS(PR_T),
        .SW_RECALL_TICKS(SR_T), .GRACE_TICKS(GR_T)
    ) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hsb_in(hsb_in),
        .hsb_oe(hsb_oe), .hsb_o(hsb_o), .sw_req(sw_req), .sw_recall(sw_recall),
        .acc_active(acc_active), .wr_strobe(wr_strobe), .nv_store(nv_store),
        .nv_recall(nv_recall), .busy(busy), .inhibit(inhibit)
    );

    // behavioural reference: 0 off, 1 power recall, 2 idle, 3 grace, 4 store, 5 sw recall
    int m_st = 0, m_left = 0;
    bit m_pend = 0, m_auto = 0;

    task automatic m_begin_store(bit a);
        m_st = 4; m_left = ST_T; m_auto = a;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pend = 0; m_auto = 0; m_left = 0;
        end else begin
            bit old_p;
            old_p = m_pend;
            if (wr_strobe && m_st == 2 && supply_ok) m_pend = 1;
            case (m_st)
                0: if (supply_ok) begin m_st = 1; m_left = PR_T; end
                1, 5: begin
                    if (!supply_ok) begin m_st = 0; m_pend = 0; end
                    else begin
                        m_left--;
                        if (m_left == 0) begin m_st = 2; m_pend = 0; end
                    end
                end
                2: begin
                    if (!supply_ok) begin
                        if (old_p) m_begin_store(1);
                        else begin m_st = 0; m_pend = 0; end
                    end else if (!hsb_in && old_p) begin m_st = 3; m_left = GR_T; end
                    else if (sw_req && !sw_recall && old_p) m_begin_store(0);
                    else if (sw_req && sw_recall) begin m_st = 5; m_left = SR_T; end
                end
                3: begin
                    if (!supply_ok) m_begin_store(1);
                    else begin
                        m_left--;
                        if (!acc_active || m_left == 0) m_begin_store(0);
                    end
                end
                4: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_pend = 0;
                        m_st = (m_auto || !supply_ok) ? 0 : 2;
                        m_auto = 0;
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 nv_store vs model",  nv_store,  m_st == 4);
            chk("R8 nv_recall vs model", nv_recall, m_st == 1 || m_st == 5);
            chk("R9 busy vs model",      busy,      m_st == 1 || m_st >= 3);
            chk("R5 hsb_oe vs model",    hsb_oe,    m_st == 3 || m_st == 4);
            chk("R2 inhibit vs model",   inhibit,   m_st != 2 || !supply_ok);
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic do_write();
        wr_strobe = 1'b1; tick(); wr_strobe = 1'b0;
    endtask

    task automatic sw_cmd(input bit rcl);
        sw_req = 1'b1; sw_recall = rcl; tick(); sw_req = 1'b0; sw_recall = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        // R1 reset state
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset nv_store", nv_store, 0);
        chk("R1 reset nv_recall", nv_recall, 0);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset inhibit", inhibit, 1);
        chk("R1 reset hsb_oe", hsb_oe, 0);
        tick();
        // R1 power-up recall length
        supply_ok = 1'b1; tick();
        @(negedge clk);
        n = 0;
        while (nv_recall) begin n++; @(negedge clk); end
        chk("R1 power-up recall length", n, PR_T);
        chk("R2 idle inhibit low", inhibit, 0);
        tick();
        // R7 store requests with nothing pending
        sw_cmd(0); @(negedge clk);
        chk("R7 sw store ignored", busy, 0);
        hsb_in = 1'b0; tick(); hsb_in = 1'b1; @(negedge clk);
        chk("R7 hw store ignored", busy, 0);
        chk("R7 pin not driven", hsb_oe, 0);
        tick();
        // R8 software store
        do_write(); sw_cmd(0); @(negedge clk);
        n = 0;
        while (nv_store) begin n++; @(negedge clk); end
        chk("R8 sw store length", n, ST_T);
        chk("R8 back to idle", inhibit, 0);
        tick();
        // R11 second store without new write
        sw_cmd(0); @(negedge clk);
        chk("R11 repeat store ignored", busy, 0);
        tick();
        // R5/R6 hardware store with access held, full grace
        do_write(); acc_active = 1'b1; hsb_in = 1'b0; tick(); hsb_in = 1'b1;
        @(negedge clk);
        chk("R5 pin driven enable", hsb_oe, 1);
        chk("R5 pin driven low", hsb_o, 0);
        chk("R5 busy", busy, 1);
        n = 0;
        while (hsb_oe && !nv_store) begin n++; @(negedge clk); end
        chk("R6 full grace length", n, GR_T);
        tick();
        // R9 requests during store are dropped
        sw_cmd(1); do_write(); acc_active = 1'b0;
        @(negedge clk);
        while (nv_store) @(negedge clk);
        chk("R9 recall not queued", nv_recall, 0);
        tick();
        sw_cmd(0); @(negedge clk);
        chk("R9 write during store ignored", busy, 0);
        tick();
        // R8 software recall, R9 write during recall ignored
        sw_cmd(1); do_write(); @(negedge clk);
        n = 1;
        while (nv_recall) begin n++; @(negedge clk); end
        chk("R8 sw recall length", n, SR_T);
        tick();
        sw_cmd(0); @(negedge clk);
        chk("R9 write during recall ignored", busy, 0);
        tick();
        // R10 supply loss over pin and software; R3 auto store then off
        do_write();
        supply_ok = 1'b0; hsb_in = 1'b0; sw_req = 1'b1; sw_recall = 1'b0;
        tick(); hsb_in = 1'b1; sw_req = 1'b0;
        @(negedge clk);
        chk("R10 supply loss wins", nv_store, 1);
        chk("R3 pin driven in auto store", hsb_oe, 1);
        n = 0;
        while (nv_store) begin n++; @(negedge clk); end
        chk("R3 auto store length", n, ST_T);
        chk("R3 off busy", busy, 0);
        chk("R3 off inhibit", inhibit, 1);
        repeat (3) tick();
        @(negedge clk);
        chk("R3 stays off", nv_recall, 0);
        supply_ok = 1'b1; tick(); @(negedge clk);
        chk("R1 recall on supply return", nv_recall, 1);
        while (nv_recall) @(negedge clk);
        tick();
        // R4 supply loss with nothing pending
        supply_ok = 1'b0; tick(); @(negedge clk);
        chk("R4 no store", nv_store, 0);
        chk("R4 not busy", busy, 0);
        // R12 supply loss during recall
        supply_ok = 1'b1; repeat (4) tick();
        supply_ok = 1'b0; tick(); @(negedge clk);
        chk("R12 recall abandoned", nv_recall, 0);
        supply_ok = 1'b1; tick(); @(negedge clk);
        while (nv_recall) @(negedge clk);
        tick();
        // R10 pin over software; R6 early grace exit
        do_write();
        hsb_in = 1'b0; sw_req = 1'b1; sw_recall = 1'b1; acc_active = 1'b0;
        tick(); hsb_in = 1'b1; sw_req = 1'b0; sw_recall = 1'b0;
        @(negedge clk);
        chk("R10 pin wins over software", hsb_oe, 1);
        chk("R10 no recall", nv_recall, 0);
        n = 0;
        while (hsb_oe && !nv_store) begin n++; @(negedge clk); end
        chk("R6 early grace exit", n, 1);
        while (nv_store) @(negedge clk);
        chk("R8 hw store returns idle", inhibit, 0);
        repeat (2) tick();
        finish_run();
    end
endmodule